// File: doc/BRIEF.md
# Four-Match Operating-System Timer with Watchdog

A free-running counter for operating-system time keeping. A prescaler divides the core clock into ticks, and the counter advances by one on each tick. On every tick the value the counter holds before it increments is compared with four match registers. Each channel that matches sets its own sticky status flag. Software acknowledges a flag by writing a one to it. Each flag can drive an interrupt line through a per-channel enable.

Channel 3 also serves as a watchdog. Once software arms the watchdog, it cannot disarm it. A later match on channel 3 then produces a one-cycle reset request for the chip's reset controller. Software keeps the system alive by moving the counter or the channel 3 match value forward before the match occurs.

Top module: `ostmr_top`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `rst_req_o` are low.
- R2: The counter increases by exactly one every `TICK_DIV` core clocks (default 3), and wraps from all ones to zero.
- R3: A write to index 4 loads the counter with the write data. Counting resumes from the loaded value.
- R4: On a tick, each channel n whose match register equals the counter value before the increment sets status bit n. Several bits may be set on the same tick.
- R5: A write to index 5 clears the status bits where the data bit is one. Status bits where the data bit is zero are left unchanged.
- R6: If a clear of status bit n and a new match on channel n fall in the same cycle, bit n ends up set.
- R7: The interrupt-enable register (index 6) keeps only data bits 3:0. `irq_o[n]` is high exactly when enable bit n and status bit n are both set.
- R8: A write to index 7 with data bit 0 set arms the watchdog. A later write with bit 0 clear leaves the watchdog armed.
- R9: A channel 3 match while the watchdog is armed raises `rst_req_o` for exactly one cycle, in the cycle after the match tick. A channel 3 match while the watchdog is not armed raises no reset request.
- R10: Register indices on `reg_addr_i` are: 0 to 3 for match channels 0 to 3, 4 for the counter, 5 for status, 6 for interrupt enable and 7 for watchdog enable. `reg_rdata_o` returns the addressed register, zero-extended, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data of the indexed register |
| irq_o | output | 4 | Per-channel interrupt requests |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The collision that matters is a software clear of a status bit landing on the same edge as a new match on that channel. The bench finds the tick phase by watching the counter change value. It then times a clear of status bit 2 so that it lands on the tick whose pre-increment count equals match 2, and requires the bit to read back as set. The bench also places software counter loads next to tick edges and requires that the loaded value, not the incremented one, appears afterwards.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_MATCH0 = 3'd0,
    IDX_MATCH1 = 3'd1,
    IDX_MATCH2 = 3'd2,
    IDX_MATCH3 = 3'd3,
    IDX_COUNT  = 3'd4,
    IDX_STAT   = 3'd5,
    IDX_IE     = 3'd6,
    IDX_WDOG   = 3'd7
  } reg_idx_e;

  localparam int unsigned WDOG_CH = NUM_CH - 1;
endpackage

// File: rtl/ostmr_prescale.sv
module ostmr_prescale #(
  parameter int unsigned DIV = 3  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] div_q;

  assign tick_o = (div_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ostmr_match.sv
module ostmr_match #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                          tick_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  match_i,
  output logic [NUM_CH-1:0]             hit_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit_o[g] = tick_i && (cnt_i == match_i[g]);
  end
endmodule

// File: rtl/ostmr_status.sv
module ostmr_status #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] clr_mask_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] stat_o
);
  logic [NUM_CH-1:0] stat_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    // a hit in the same cycle overrides the clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       stat_q[g] <= 1'b0;
      else if (hit_i[g])                 stat_q[g] <= 1'b1;
      else if (clr_we_i && clr_mask_i[g]) stat_q[g] <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
  import ostmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_DIV = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              rst_req_o
);
  logic                         tick;
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0] match_q;
  logic [NUM_CH-1:0]            ie_q;
  logic                         wdog_q;
  logic                         rst_req_q;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            stat;
  logic                         we_cnt, we_stat, we_ie, we_wdog;

  assign we_cnt  = reg_we_i && (reg_addr_i == IDX_COUNT);
  assign we_stat = reg_we_i && (reg_addr_i == IDX_STAT);
  assign we_ie   = reg_we_i && (reg_addr_i == IDX_IE);
  assign we_wdog = reg_we_i && (reg_addr_i == IDX_WDOG);

  ostmr_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ostmr_match #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_match (
    .tick_i  (tick),
    .cnt_i   (cnt_q),
    .match_i (match_q),
    .hit_o   (hit)
  );

  ostmr_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (we_stat),
    .clr_mask_i (reg_wdata_i[NUM_CH-1:0]),
    .hit_i      (hit),
    .stat_o     (stat)
  );

  // software load wins over the tick increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (we_cnt) cnt_q <= reg_wdata_i;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q[g] <= '0;
      else if (reg_we_i && (reg_addr_i == IDX_W'(g))) match_q[g] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q      <= '0;
      wdog_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (we_ie) ie_q <= reg_wdata_i[NUM_CH-1:0];
      if (we_wdog && reg_wdata_i[0]) wdog_q <= 1'b1;  // set-only
      rst_req_q <= hit[WDOG_CH] && wdog_q;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      IDX_MATCH0, IDX_MATCH1,
      IDX_MATCH2, IDX_MATCH3: reg_rdata_o = match_q[reg_addr_i[1:0]];
      IDX_COUNT:              reg_rdata_o = cnt_q;
      IDX_STAT:               reg_rdata_o = CNT_W'(stat);
      IDX_IE:                 reg_rdata_o = CNT_W'(ie_q);
      IDX_WDOG:               reg_rdata_o = CNT_W'(wdog_q);
      default:                reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = ie_q & stat;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         tick,
  input logic                         we,
  input logic [2:0]                   addr,
  input logic [CNT_W-1:0]             wdata,
  input logic [CNT_W-1:0]             cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] match,
  input logic [NUM_CH-1:0]            status,
  input logic                         wdog_en,
  input logic                         rst_req,
  input logic [NUM_CH-1:0]            irq
);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !(we && addr == 3'd4)) |=> (cnt == CNT_W'($past(cnt) + 1)));

  assert_cnt_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == 3'd4) |=> (cnt == $past(wdata)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    assert_match_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && cnt == match[g]) |=> status[g]);
  end

  assert_stat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !(we && addr == 3'd5)) |=> (status == $past(status)));

  assert_irq_subset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq & ~status) == '0));

  assert_wdog_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_en |=> wdog_en);

  assert_rst_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> !rst_req);

  assert_rst_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |-> $past(tick && cnt == match[NUM_CH-1] && wdog_en));
endmodule

bind ostmr_top ostmr_chk #(.CNT_W(CNT_W), .NUM_CH(ostmr_pkg::NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick    (tick),
  .we      (reg_we_i),
  .addr    (reg_addr_i),
  .wdata   (reg_wdata_i),
  .cnt     (cnt_q),
  .match   (match_q),
  .status  (stat),
  .wdog_en (wdog_q),
  .rst_req (rst_req_o),
  .irq     (irq_o)
);

// File: tb/ostmr_top_tb.sv
module ostmr_top_tb;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [3:0]   irq;
  logic         rst_req;
  int           n_chk = 0;
  int           n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  ostmr_top #(.CNT_W(W), .TICK_DIV(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; write lands on the following posedge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cnt(input logic [W-1:0] v, output bit ok);
    logic [W-1:0] c;
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      rd(3'd4, c);
      if (c == v) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_rst(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reg zero", d, '0);
    end
    chk("R1 irq low", W'(irq), '0);
    chk("R1 rst_req low", W'(rst_req), '0);
  endtask

  task automatic t_regmap;
    logic [W-1:0] d;
    wr(3'd0, 32'h1111_0000); wr(3'd1, 32'h2222_0001);
    wr(3'd2, 32'h3333_0002); wr(3'd3, 32'h4444_0003);
    rd(3'd0, d); chk("R10 match0", d, 32'h1111_0000);
    rd(3'd1, d); chk("R10 match1", d, 32'h2222_0001);
    rd(3'd2, d); chk("R10 match2", d, 32'h3333_0002);
    rd(3'd3, d); chk("R10 match3", d, 32'h4444_0003);
  endtask

  task automatic t_count;
    logic [W-1:0] a, b;
    bit ok;
    rd(3'd4, a);
    repeat (3) @(negedge clk);
    rd(3'd4, b); chk("R2 step per 3 clocks", b, a + 1);
    repeat (6) @(negedge clk);
    rd(3'd4, a); chk("R2 two steps per 6 clocks", a, b + 2);
    wr(3'd4, 32'hABCD_0000);
    rd(3'd4, a); chk("R3 load", a, 32'hABCD_0000);
    repeat (3) @(negedge clk);
    rd(3'd4, b); chk("R3 resume from load", b, 32'hABCD_0001);
    wr(3'd4, 32'hFFFF_FFFF);
    wait_cnt(32'h0, ok); chk("R2 wrap to zero", W'(ok), 1);
  endtask

  task automatic t_match;
    logic [W-1:0] d;
    bit ok;
    wr(3'd0, 1000); wr(3'd1, 1000); wr(3'd2, 2000); wr(3'd3, 3000);
    wr(3'd5, 32'hF);
    rd(3'd5, d); chk("R5 clear all", d, 0);
    wr(3'd4, 995);
    wait_cnt(1001, ok); chk("R4 reached", W'(ok), 1);
    rd(3'd5, d); chk("R4 two channels same tick", d, 32'h3);
    wr(3'd5, 32'h1);
    rd(3'd5, d); chk("R5 clear bit0 only", d, 32'h2);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R5 zero mask no effect", d, 32'h2);
    wr(3'd5, 32'h2);
    rd(3'd5, d); chk("R5 clear bit1", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [W-1:0] d;
    bit ok;
    wr(3'd2, 1500);
    wr(3'd4, 1499);
    wait_cnt(1500, ok); chk("R6 phase found", W'(ok), 1);
    // count became 1500 on the last edge; next tick is 3 edges later
    @(negedge clk); @(negedge clk);
    wr(3'd5, 32'h4);
    rd(3'd5, d); chk("R6 match beats clear", d & 32'h4, 32'h4);
    rd(3'd4, d); chk("R6 tick on that edge", d, 1501);
    wr(3'd5, 32'h4);
    rd(3'd5, d); chk("R5 later clear works", d, 0);
  endtask

  task automatic t_wdog;
    logic [W-1:0] d;
    int p;
    wr(3'd3, 4000); wr(3'd5, 32'hF);
    wr(3'd4, 3998);
    count_rst(15, p); chk("R9 no pulse when disarmed", W'(p), 0);
    rd(3'd5, d); chk("R4 ch3 flag while disarmed", d & 32'h8, 32'h8);
    wr(3'd7, 32'h1);
    rd(3'd7, d); chk("R8 armed", d, 1);
    wr(3'd5, 32'hF);
    wr(3'd4, 3998);
    count_rst(15, p); chk("R9 single pulse when armed", W'(p), 1);
    wr(3'd7, 32'h0);
    rd(3'd7, d); chk("R8 zero write ignored", d, 1);
  endtask

  task automatic t_irq;
    logic [W-1:0] d;
    bit ok;
    for (int c = 0; c < 4; c++) wr(3'(c), 5000);
    wr(3'd5, 32'hF);
    wr(3'd6, 32'h5);
    wr(3'd4, 4999);
    wait_cnt(5001, ok); chk("R7 reached", W'(ok), 1);
    chk("R7 gated irq", W'(irq), 32'h5);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R7 enable keeps 4 bits", d, 32'hF);
    chk("R7 all irq", W'(irq), 32'hF);
    wr(3'd5, 32'h1);
    chk("R7 irq follows clear", W'(irq), 32'hE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    @(negedge clk);
    t_regmap;
    t_count;
    t_match;
    t_collide;
    t_wdog;
    t_irq;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule